// File: doc/BRIEF.md
# Paged Address Translator with Access Protection

This block turns a 32-bit logical address issued by a processor into a physical address. The page map is held in registers inside the block, with one 32-bit entry per logical page. Pages are 4 KiB. The low twelve address bits pass through unchanged as the offset. The upper bits select an entry, and that entry supplies the physical frame number and a set of permission flags. Every request states whether it reads or writes, and whether the processor is in user or kernel mode. The block either returns the translated address or raises an exception with a two-bit cause, and in that case no physical access is produced.

The requester offers a request with a valid/ready handshake. The answer appears from a registered output stage one clock after the request is accepted, and it stays there until the consumer takes it. A separate configuration port lets privileged software read and replace entries. Any attempt on that port from user mode is refused and reported. The block records usage in each entry: a flag set on any permitted access, and another flag set on any permitted write. Later page-replacement software reads these flags.

Top module: `page_xlate`

## Requirements
- R1: After reset every map entry reads as zero, which marks it invalid. rsp_valid, rsp_fault, cfg_fault and cfg_rdata are all zero.
- R2: Entry layout: the frame number is in bits [31:12]. Bit 0 is valid, bit 1 is writable, bit 2 is kernel-only, bit 3 is accessed and bit 4 is modified. A translated address is the entry's bits [31:12] joined with logical address bits [11:0].
- R3: An access that passes every check returns rsp_cause 00 with rsp_fault low.
- R4: An access to an entry whose valid bit is 0 gives rsp_cause 01. So does an access whose logical page number is at or beyond MAP_DEPTH. In both cases rsp_fault is high and rsp_paddr is zero.
- R5: A write to a valid entry whose writable bit is 0 gives rsp_cause 10. A read of the same entry is permitted.
- R6: A user-mode access to a valid entry whose kernel-only bit is 1 gives rsp_cause 11. The same access in kernel mode is permitted.
- R7: When several checks fail at once, the cause reported is invalid first, then kernel-only, then write protection.
- R8: A permitted access sets the entry's accessed bit (bit 3), and a permitted write also sets its modified bit (bit 4). A faulted access changes neither bit.
- R9: A kernel-mode configuration write replaces the indexed entry. If it lands in the same cycle as a usage-flag update to that entry, the written value wins. A kernel-mode configuration read shows the entry on cfg_rdata in the next cycle. A user-mode configuration access changes no entry and no cfg_rdata value, and it pulses cfg_fault for one cycle in the next cycle.
- R10: req_ready equals (not rsp_valid) or rsp_ready. The response is valid in the cycle after acceptance, and while rsp_ready is low the response holds valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_laddr | input | ADDR_W | Logical address |
| req_write | input | 1 | 1 for write access, 0 for read |
| req_kernel | input | 1 | 1 when the requester is in kernel mode |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | ADDR_W | Physical address, zero on fault |
| rsp_fault | output | 1 | Exception toward the processor |
| rsp_cause | output | 2 | Fault cause: 00 none, 01 invalid, 10 read-only, 11 kernel-only |
| cfg_en | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 writes the entry, 0 reads it |
| cfg_kernel | input | 1 | Mode of the configuration access |
| cfg_index | input | IDX_W | Entry selected for configuration |
| cfg_wdata | input | ADDR_W | New entry value |
| cfg_rdata | output | ADDR_W | Entry value from the last kernel read |
| cfg_fault | output | 1 | One-cycle pulse after a refused user-mode access |

## Verification
The assertions check the following on every cycle: the handshake timing and response stability, the zero address on faults, and the offset passing through into translated addresses. They also check that a read-only cause comes only from a write, that a kernel-only cause comes only from a user request, and that the configuration fault pulse matches the mode of the access. Other behaviour depends on what the map holds, and only the bench's scenarios can show it. That covers the frame substitution, the priority among causes when an entry violates several rules, the setting of the accessed and modified flags, and the refusal of user-mode writes to entries. The bench model predicts these from its own copy of the map.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'b00,
      CAUSE_INVALID = 2'b01,
      CAUSE_RDONLY  = 2'b10,
      CAUSE_PRIV    = 2'b11
   } xl_cause_e;

   localparam int FLAG_VALID = 0;
   localparam int FLAG_WRITE = 1;
   localparam int FLAG_KONLY = 2;
   localparam int FLAG_ACC   = 3;
   localparam int FLAG_MOD   = 4;
   localparam int FLAG_COUNT = 5;

endpackage

// File: rtl/pm_store.sv
module pm_store
   import page_xlate_pkg::*;
#(
   parameter int ENT_W = 32,
   parameter int DEPTH = 16,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        touch_en,
   input  logic                        touch_wr,
   input  logic [IDX_W-1:0]            touch_idx,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [ENT_W-1:0]            wr_data,
   output logic [DEPTH-1:0][ENT_W-1:0] map_q
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [ENT_W-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            ent_q <= wr_data;
         end else if (touch_en && (touch_idx == IDX_W'(g))) begin
            ent_q[FLAG_ACC] <= 1'b1;
            if (touch_wr) ent_q[FLAG_MOD] <= 1'b1;
         end
      end
      assign map_q[g] = ent_q;
   end

endmodule

// File: rtl/pm_check.sv
module pm_check
   import page_xlate_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 12,
   parameter int DEPTH    = 16,
   localparam int PAGE_W  = ADDR_W - OFFSET_W,
   localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [DEPTH-1:0][ADDR_W-1:0] map_q,
   input  logic [PAGE_W-1:0]            lpn,
   input  logic                         is_write,
   input  logic                         is_kernel,
   output logic [IDX_W-1:0]             idx,
   output logic [PAGE_W-1:0]            frame,
   output xl_cause_e                    cause
);

   logic              in_range;
   logic [ADDR_W-1:0] ent;

   if (longint'(DEPTH) < (longint'(1) << PAGE_W)) begin : g_bounded
      assign in_range = (lpn < PAGE_W'(DEPTH));
   end else begin : g_full
      assign in_range = 1'b1;
   end

   assign idx   = lpn[IDX_W-1:0];
   assign ent   = map_q[idx];
   assign frame = ent[ADDR_W-1:OFFSET_W];

   always_comb begin
      if (!in_range || !ent[FLAG_VALID])        cause = CAUSE_INVALID;
      else if (ent[FLAG_KONLY] && !is_kernel)   cause = CAUSE_PRIV;
      else if (is_write && !ent[FLAG_WRITE])    cause = CAUSE_RDONLY;
      else                                      cause = CAUSE_NONE;
   end

endmodule

// File: rtl/page_xlate.sv
module page_xlate
   import page_xlate_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int OFFSET_W  = 12,
   parameter int MAP_DEPTH = 16,
   localparam int IDX_W    = (MAP_DEPTH > 1) ? $clog2(MAP_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_laddr,
   input  logic              req_write,
   input  logic              req_kernel,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              rsp_fault,
   output logic [1:0]        rsp_cause,
   input  logic              cfg_en,
   input  logic              cfg_write,
   input  logic              cfg_kernel,
   input  logic [IDX_W-1:0]  cfg_index,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   output logic              cfg_fault
);

   localparam int PAGE_W = ADDR_W - OFFSET_W;

   if (OFFSET_W < FLAG_COUNT || OFFSET_W >= ADDR_W) begin : g_bad_offset
      $error("page_xlate: OFFSET_W must leave room for flags and frame");
   end
   if (MAP_DEPTH < 2 || (MAP_DEPTH & (MAP_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("page_xlate: MAP_DEPTH must be a power of two of at least 2");
   end
   if (longint'(MAP_DEPTH) > (longint'(1) << PAGE_W)) begin : g_bad_span
      $error("page_xlate: MAP_DEPTH exceeds the logical page space");
   end

   logic [MAP_DEPTH-1:0][ADDR_W-1:0] map_q;
   logic [IDX_W-1:0]                 hit_idx;
   logic [PAGE_W-1:0]                hit_frame;
   xl_cause_e                        hit_cause;
   logic                             accept;
   logic                             cfg_wr_ok;
   logic                             cfg_rd_ok;

   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;
   assign cfg_wr_ok = cfg_en && cfg_kernel && cfg_write;
   assign cfg_rd_ok = cfg_en && cfg_kernel && !cfg_write;

   pm_check #(
      .ADDR_W  (ADDR_W),
      .OFFSET_W(OFFSET_W),
      .DEPTH   (MAP_DEPTH)
   ) u_check (
      .map_q    (map_q),
      .lpn      (req_laddr[ADDR_W-1:OFFSET_W]),
      .is_write (req_write),
      .is_kernel(req_kernel),
      .idx      (hit_idx),
      .frame    (hit_frame),
      .cause    (hit_cause)
   );

   pm_store #(
      .ENT_W(ADDR_W),
      .DEPTH(MAP_DEPTH)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .touch_en (accept && (hit_cause == CAUSE_NONE)),
      .touch_wr (req_write),
      .touch_idx(hit_idx),
      .wr_en    (cfg_wr_ok),
      .wr_idx   (cfg_index),
      .wr_data  (cfg_wdata),
      .map_q    (map_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= 1'b0;
         rsp_cause <= CAUSE_NONE;
      end else if (accept) begin
         rsp_valid <= 1'b1;
         rsp_fault <= (hit_cause != CAUSE_NONE);
         rsp_cause <= hit_cause;
         rsp_paddr <= (hit_cause == CAUSE_NONE) ?
                      {hit_frame, req_laddr[OFFSET_W-1:0]} : '0;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_rdata <= '0;
         cfg_fault <= 1'b0;
      end else begin
         cfg_fault <= cfg_en && !cfg_kernel;
         if (cfg_rd_ok) cfg_rdata <= map_q[cfg_index];
      end
   end

endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
   parameter int ADDR_W    = 32,
   parameter int OFFSET_W  = 12,
   parameter int MAP_DEPTH = 16,
   localparam int IDX_W    = (MAP_DEPTH > 1) ? $clog2(MAP_DEPTH) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_laddr,
   input logic              req_write,
   input logic              req_kernel,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic              rsp_fault,
   input logic [1:0]        rsp_cause,
   input logic              cfg_en,
   input logic              cfg_write,
   input logic              cfg_kernel,
   input logic [IDX_W-1:0]  cfg_index,
   input logic [ADDR_W-1:0] cfg_wdata,
   input logic [ADDR_W-1:0] cfg_rdata,
   input logic              cfg_fault
);

   logic [OFFSET_W-1:0] off_q;
   logic                wr_q;
   logic                kern_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q  <= '0;
         wr_q   <= 1'b0;
         kern_q <= 1'b0;
      end else if (req_valid && req_ready) begin
         off_q  <= req_laddr[OFFSET_W-1:0];
         wr_q   <= req_write;
         kern_q <= req_kernel;
      end
   end

   // R2: offset bits survive translation
   p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_paddr[OFFSET_W-1:0] == off_q);

   p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_paddr == '0);

   p_rdonly_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_cause == 2'b10 |-> wr_q);

   p_priv_on_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_cause == 2'b11 |-> !kern_q);

   p_user_cfg_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en && !cfg_kernel |=> cfg_fault);

   p_kernel_cfg_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_en && !cfg_kernel) |=> !cfg_fault);

   p_ready_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> req_ready);

   p_accept_then_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid);

   p_hold_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
                                  && $stable(rsp_cause) && $stable(rsp_fault));

endmodule

bind page_xlate page_xlate_chk #(
   .ADDR_W   (ADDR_W),
   .OFFSET_W (OFFSET_W),
   .MAP_DEPTH(MAP_DEPTH)
) u_chk (.*);

// File: tb/page_xlate_test.sv
module page_xlate_test;

   localparam int AW    = 32;
   localparam int OW    = 12;
   localparam int DEPTH = 16;
   localparam int IW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_kernel = 1'b0;
   logic [AW-1:0] req_laddr = '0;
   logic          req_ready;
   logic          rsp_valid, rsp_fault;
   logic          rsp_ready = 1'b1;
   logic [AW-1:0] rsp_paddr;
   logic [1:0]    rsp_cause;
   logic          cfg_en = 1'b0, cfg_write = 1'b0, cfg_kernel = 1'b0;
   logic [IW-1:0] cfg_index = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic [AW-1:0] cfg_rdata;
   logic          cfg_fault;

   int checks = 0;
   int fails  = 0;
   bit running = 0;

   always #5 clk = ~clk;

   page_xlate #(.ADDR_W(AW), .OFFSET_W(OW), .MAP_DEPTH(DEPTH)) uut (.*);

   // reference model state
   logic [AW-1:0] m_map [DEPTH];
   logic          e_valid, e_fault, e_cfault;
   logic [AW-1:0] e_paddr, e_rdata;
   logic [1:0]    e_cause;
   int            e_nfail;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) m_map[i] = '0;
         e_valid = 0; e_fault = 0; e_cfault = 0; e_paddr = '0; e_rdata = '0;
         e_cause = 2'b00; e_nfail = 0;
      end else begin
         logic acc;
         logic [AW-1:0] ent;
         int lp;
         bit bad_v, bad_k, bad_w;
         acc = req_valid && (!e_valid || rsp_ready);
         if (e_valid && rsp_ready) e_valid = 0;
         if (cfg_en && cfg_kernel && !cfg_write) e_rdata = m_map[cfg_index];
         e_cfault = cfg_en && !cfg_kernel;
         if (acc) begin
            lp  = int'(req_laddr[AW-1:OW]);
            ent = (lp < DEPTH) ? m_map[lp] : '0;
            bad_v = !ent[0];
            bad_k = ent[2] && !req_kernel;
            bad_w = req_write && !ent[1];
            e_nfail = int'(bad_v) + int'(bad_k) + int'(bad_w);
            if (bad_v)      e_cause = 2'b01;
            else if (bad_k) e_cause = 2'b11;
            else if (bad_w) e_cause = 2'b10;
            else            e_cause = 2'b00;
            e_fault = (e_cause != 2'b00);
            e_paddr = e_fault ? '0 : {ent[AW-1:OW], req_laddr[OW-1:0]};
            if (!e_fault) begin
               m_map[lp][3] = 1'b1;
               if (req_write) m_map[lp][4] = 1'b1;
            end
            e_valid = 1;
         end
         if (cfg_en && cfg_kernel && cfg_write) m_map[cfg_index] = cfg_wdata;
      end
   end

   task automatic check(string tag, bit ok, logic [AW-1:0] act, logic [AW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string cause_tag();
      if (e_nfail > 1)        return "R7";
      case (e_cause)
         2'b01:   return "R4";
         2'b10:   return "R5";
         2'b11:   return "R6";
         default: return "R2";
      endcase
   endfunction

   always @(negedge clk) begin
      if (running) begin
         check("R10 rsp_valid", rsp_valid == e_valid, AW'(rsp_valid), AW'(e_valid));
         check("R10 req_ready", req_ready == (!e_valid || rsp_ready),
               AW'(req_ready), AW'(!e_valid || rsp_ready));
         if (e_valid) begin
            check(cause_tag(), rsp_cause == e_cause, AW'(rsp_cause), AW'(e_cause));
            check(e_fault ? "R4 fault/paddr" : "R3 paddr",
                  rsp_fault == e_fault && rsp_paddr == e_paddr, rsp_paddr, e_paddr);
         end
         check("R9 cfg_fault", cfg_fault == e_cfault, AW'(cfg_fault), AW'(e_cfault));
         check((cfg_rdata[4:3] != e_rdata[4:3]) ? "R8 flags" : "R9 cfg_rdata",
               cfg_rdata == e_rdata, cfg_rdata, e_rdata);
      end
   end

   task automatic cyc();
      @(posedge clk); #2;
   endtask

   task automatic quiet();
      req_valid = 0; cfg_en = 0;
   endtask

   task automatic cfg_op(bit wr, bit kern, int idx, logic [AW-1:0] data);
      cfg_en = 1; cfg_write = wr; cfg_kernel = kern;
      cfg_index = IW'(idx); cfg_wdata = data;
      cyc(); quiet();
   endtask

   task automatic access(logic [AW-1:0] a, bit wr, bit kern);
      req_valid = 1; req_laddr = a; req_write = wr; req_kernel = kern;
      cyc(); quiet();
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1;
      @(negedge clk);
      // R1: reset state at the ports
      check("R1 rsp_valid", rsp_valid == 0, AW'(rsp_valid), '0);
      check("R1 cfg_fault", cfg_fault == 0, AW'(cfg_fault), '0);
      check("R1 cfg_rdata", cfg_rdata == '0, cfg_rdata, '0);
      running = 1;
      cyc();
      // R1: every entry reads as zero
      for (int i = 0; i < DEPTH; i++) cfg_op(0, 1, i, '0);
      access(32'h0000_0123, 0, 1);          // R4: invalid after reset

      // R9: kernel writes populate the map (R2 layout)
      cfg_op(1, 1, 0, 32'h0007_3003);       // valid, writable
      cfg_op(1, 1, 1, 32'h0011_5001);       // valid, read-only
      cfg_op(1, 1, 2, 32'hABCD_E007);       // valid, writable, kernel-only
      cfg_op(1, 1, 3, 32'h0000_0006);       // invalid with W and K set
      cfg_op(1, 1, 4, 32'h0040_4005);       // valid, kernel-only, read-only
      cfg_op(1, 0, 5, 32'hFFFF_F01F);       // R9: user write refused
      cfg_op(0, 1, 5, '0);                  // reads back zero
      cfg_op(0, 0, 0, '0);                  // R9: user read refused

      access(32'h0000_0ABC, 0, 0);          // R3
      access(32'h0000_0FFF, 1, 0);          // R3, sets modified
      access(32'h0000_1450, 0, 0);          // R5 read allowed
      access(32'h0000_1450, 1, 0);          // R5
      access(32'h0000_1001, 1, 1);          // R5 in kernel mode
      access(32'h0000_2777, 0, 0);          // R6
      access(32'h0000_2777, 1, 1);          // R6 kernel ok
      access(32'h0000_3000, 1, 0);          // R7 invalid wins
      access(32'h1234_5678, 0, 1);          // R4 out of range
      access(32'h0001_0000, 0, 1);          // R4 first page past depth
      access(32'h0000_4010, 1, 0);          // R7 kernel-only wins
      access(32'h0000_4010, 1, 1);          // R5
      access(32'h0000_4010, 0, 1);          // R3

      // R8: flags visible through config reads
      for (int i = 0; i < 6; i++) cfg_op(0, 1, i, '0);

      // R9: config write wins over same-cycle flag update
      req_valid = 1; req_laddr = 32'h0000_1234; req_write = 0; req_kernel = 0;
      cfg_en = 1; cfg_write = 1; cfg_kernel = 1; cfg_index = 1; cfg_wdata = 32'h0022_2003;
      cyc(); quiet();
      cfg_op(0, 1, 1, '0);
      access(32'h0000_1234, 1, 0);          // now writable

      // R10: back-pressure
      rsp_ready = 0;
      req_valid = 1; req_laddr = 32'h0000_0010; req_write = 0; req_kernel = 0;
      repeat (3) cyc();
      req_laddr = 32'h0000_2020; req_kernel = 1;
      repeat (2) cyc();
      rsp_ready = 1;
      repeat (2) cyc();
      quiet();
      for (int i = 0; i < 4; i++) begin
         rsp_ready = i[0];
         access(32'h0000_0100 + (i << 12), i[1], 0);
      end
      rsp_ready = 1;
      repeat (3) cyc();
      for (int i = 0; i < 5; i++) cfg_op(0, 1, i, '0);
      cyc();
      running = 0;
      summary();
   end

endmodule